// File: doc/BRIEF.md
# Chained Countdown Timer Array

The block holds a row of timer modules. Each module owns two half-width countdown timers, A and B, which can also be fused into a single double-width timer run by A's controls. Every timer counts down from its load value in either one-shot or periodic mode. When its counter reaches zero it raises a time-out pulse for one clock.

A timer can be told to wait before it counts. A waiting timer that has been started stays idle until the timer in front of it in a fixed chain times out. It then loads its value and runs. The chain follows module index. When a module runs fused, the time-out of its A timer feeds A of the next module. When a module runs split, A feeds B of the same module and B feeds A of the next module.

Software can start several timers at once and let one free-running timer release the others in order. This gives a sequence of timed events from a single start.

Top module: `tca_array`

## Requirements
- R1: While reset is held and after it is released, with no start pulse given, every time-out output stays low.
- R2: A timer with its wait bit clear that sees a start pulse in cycle c, with load value L, raises its time-out output for one clock in cycle c+1+L.
- R3: In one-shot mode (mode bit 0) a timer times out once and then stays idle. In periodic mode (mode bit 1) it reloads after each time-out, so the pulses are L+1 cycles apart.
- R4: A started timer with its wait bit set does not count until a trigger arrives. A trigger in cycle t makes it time out in cycle t+1+L.
- R5: In a split module (width select 0), A's time-out triggers B of the same module, and B's time-out triggers A of the next module.
- R6: In a fused module (width select 1), A counts the double-width value {B load, A load}, A's time-out triggers A of the next module, and B stays idle with its time-out output low.
- R7: The wait bit of A in module 0 has no effect: that timer always starts counting at once.
- R8: A trigger that arrives while the receiving timer is not started is not remembered.
- R9: A released periodic timer keeps reloading without further triggers. A stop pulse in cycle s ends it, and no time-out follows after cycle s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mod_full | input | NUM_MOD | Per-module width select, 1 = fused |
| ld_a | input | NUM_MOD*HALF_W | Load values of the A timers |
| ld_b | input | NUM_MOD*HALF_W | Load values of the B timers (upper half when fused) |
| per_a | input | NUM_MOD | A mode, 1 = periodic |
| per_b | input | NUM_MOD | B mode, 1 = periodic |
| wait_a | input | NUM_MOD | A wait-for-trigger enable |
| wait_b | input | NUM_MOD | B wait-for-trigger enable |
| start_a | input | NUM_MOD | A start pulse |
| start_b | input | NUM_MOD | B start pulse |
| stop_a | input | NUM_MOD | A stop pulse |
| stop_b | input | NUM_MOD | B stop pulse |
| tmo_a | output | NUM_MOD | A time-out pulses |
| tmo_b | output | NUM_MOD | B time-out pulses |

## Verification
On every cycle the assertions check the local rules of each counter. A waiting timer holds its count until it is triggered. A trigger reloads it. One-shot timers drop their enable after the time-out, periodic timers reload, a stop clears the timer, the head timer is never held, and a fused module keeps B silent. Only the bench scenarios can show how the chain behaves as a whole. They check the exact cycle of every time-out along split, fused and mixed chains, the double-width load, and that an early trigger is lost. The scoreboard also catches time-outs that are missing or extra.

// File: rtl/tca_pkg.sv
package tca_pkg;
   // count mode encoding shared by every timer
   typedef enum logic {
      MODE_ONESHOT  = 1'b0,
      MODE_PERIODIC = 1'b1
   } tca_mode_e;
   localparam int TIMERS_PER_MOD = 2;
endpackage

// File: rtl/tca_counter.sv
module tca_counter #(
   parameter int W          = 16,
   parameter bit ALLOW_WAIT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         stop,
   input  logic         wait_en,
   input  logic         mode,
   input  logic [W-1:0] load,
   input  logic         trig,
   output logic         tmo
);
   import tca_pkg::*;

   localparam logic [W-1:0] ZERO = '0;

   logic         en_q, rel_q;
   logic [W-1:0] cnt_q;
   logic         wait_eff;
   tca_mode_e    mode_e;

   generate
      if (W < 1) begin : g_bad_w
         $error("tca_counter: W must be at least 1");
      end
      if (ALLOW_WAIT) begin : g_wait
         assign wait_eff = wait_en;
      end else begin : g_head
         // head of chain: nothing can release it, so never hold it
         assign wait_eff = wait_en & 1'b0;
      end
   endgenerate

   assign mode_e = tca_mode_e'(mode);
   assign tmo    = en_q & rel_q & (cnt_q == ZERO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         rel_q <= 1'b0;
         cnt_q <= ZERO;
      end else if (stop) begin
         en_q  <= 1'b0;
         rel_q <= 1'b0;
      end else if (start) begin
         en_q  <= 1'b1;
         rel_q <= ~wait_eff;
         cnt_q <= load;
      end else if (en_q) begin
         if (!rel_q) begin
            if (trig) begin
               rel_q <= 1'b1;
               cnt_q <= load;
            end
         end else if (cnt_q == ZERO) begin
            if (mode_e == MODE_PERIODIC) begin
               cnt_q <= load;
            end else begin
               en_q  <= 1'b0;
               rel_q <= 1'b0;
            end
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   // R4: a held timer keeps its count until triggered
   p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      en_q && !rel_q && !trig && !start && !stop |=> !rel_q && $stable(cnt_q));
   // R4: a trigger releases and loads
   p_release_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      en_q && !rel_q && trig && !start && !stop |=> rel_q && cnt_q == $past(load));
   // R3: one-shot ends after its time-out
   p_oneshot_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tmo && mode_e == MODE_ONESHOT && !start && !stop |=> !en_q);
   // R3 / R9: periodic reloads with no new trigger
   p_periodic_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tmo && mode_e == MODE_PERIODIC && !start && !stop |=> en_q && rel_q && cnt_q == $past(load));
   // R9: stop ends the timer
   p_stop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !en_q && !tmo);

   generate
      if (!ALLOW_WAIT) begin : g_head_chk
         // R7: head timer is released on start
         p_head_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
            start && !stop |=> rel_q);
      end
   endgenerate
endmodule

// File: rtl/tca_module.sv
module tca_module #(
   parameter int W       = 16,
   parameter bit IS_HEAD = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         full,
   input  logic [W-1:0] ld_a,
   input  logic [W-1:0] ld_b,
   input  logic         per_a,
   input  logic         per_b,
   input  logic         wait_a,
   input  logic         wait_b,
   input  logic         start_a,
   input  logic         start_b,
   input  logic         stop_a,
   input  logic         stop_b,
   input  logic         trig_in,
   output logic         tmo_a,
   output logic         tmo_b,
   output logic         trig_out
);
   localparam int WA = 2 * W;

   logic [WA-1:0] load_a;
   logic          trig_b;

   // fused: B supplies the upper half of A's load
   assign load_a   = full ? {ld_b, ld_a} : {{W{1'b0}}, ld_a};
   assign trig_b   = ~full & tmo_a;
   assign trig_out = full ? tmo_a : tmo_b;

   tca_counter #(.W(WA), .ALLOW_WAIT(!IS_HEAD)) u_a (
      .clk(clk), .rst_n(rst_n), .start(start_a), .stop(stop_a),
      .wait_en(wait_a), .mode(per_a), .load(load_a), .trig(trig_in),
      .tmo(tmo_a));

   tca_counter #(.W(W), .ALLOW_WAIT(1'b1)) u_b (
      .clk(clk), .rst_n(rst_n), .start(start_b & ~full), .stop(stop_b | full),
      .wait_en(wait_b), .mode(per_b), .load(ld_b), .trig(trig_b),
      .tmo(tmo_b));

   // R6: B is silent while the module stays fused
   p_b_quiet_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      full && $past(full) |-> !tmo_b);
endmodule

// File: rtl/tca_array.sv
module tca_array #(
   parameter int NUM_MOD = 4,
   parameter int HALF_W  = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_MOD-1:0]        mod_full,
   input  logic [NUM_MOD*HALF_W-1:0] ld_a,
   input  logic [NUM_MOD*HALF_W-1:0] ld_b,
   input  logic [NUM_MOD-1:0]        per_a,
   input  logic [NUM_MOD-1:0]        per_b,
   input  logic [NUM_MOD-1:0]        wait_a,
   input  logic [NUM_MOD-1:0]        wait_b,
   input  logic [NUM_MOD-1:0]        start_a,
   input  logic [NUM_MOD-1:0]        start_b,
   input  logic [NUM_MOD-1:0]        stop_a,
   input  logic [NUM_MOD-1:0]        stop_b,
   output logic [NUM_MOD-1:0]        tmo_a,
   output logic [NUM_MOD-1:0]        tmo_b
);
   logic [NUM_MOD-1:0] chain_out;
   logic [NUM_MOD-1:0] chain_in;

   generate
      if (NUM_MOD < 1 || HALF_W < 2) begin : g_bad_cfg
         $error("tca_array: need NUM_MOD >= 1 and HALF_W >= 2");
      end
      for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
         if (m == 0) begin : g_first
            assign chain_in[m] = 1'b0;
         end else begin : g_next
            assign chain_in[m] = chain_out[m-1];
         end
         tca_module #(.W(HALF_W), .IS_HEAD(m == 0)) u_mod (
            .clk(clk), .rst_n(rst_n), .full(mod_full[m]),
            .ld_a(ld_a[m*HALF_W +: HALF_W]), .ld_b(ld_b[m*HALF_W +: HALF_W]),
            .per_a(per_a[m]), .per_b(per_b[m]),
            .wait_a(wait_a[m]), .wait_b(wait_b[m]),
            .start_a(start_a[m]), .start_b(start_b[m]),
            .stop_a(stop_a[m]), .stop_b(stop_b[m]),
            .trig_in(chain_in[m]), .tmo_a(tmo_a[m]), .tmo_b(tmo_b[m]),
            .trig_out(chain_out[m]));
      end
   endgenerate

   // R1: nothing fires in the cycle right after reset
   p_quiet_after_reset_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> tmo_a == '0 && tmo_b == '0);
endmodule

// File: tb/tca_array_test.sv
`timescale 1ns/1ps
module tca_array_test;
   localparam int N = 4;
   localparam int W = 16;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic           rst_n;
   logic [N-1:0]   mod_full, per_a, per_b, wait_a, wait_b;
   logic [N-1:0]   start_a, start_b, stop_a, stop_b, tmo_a, tmo_b;
   logic [N*W-1:0] ld_a, ld_b;

   tca_array #(.NUM_MOD(N), .HALF_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .mod_full(mod_full), .ld_a(ld_a), .ld_b(ld_b),
      .per_a(per_a), .per_b(per_b), .wait_a(wait_a), .wait_b(wait_b),
      .start_a(start_a), .start_b(start_b), .stop_a(stop_a), .stop_b(stop_b),
      .tmo_a(tmo_a), .tmo_b(tmo_b));

   int    cyc = 0;
   int    s_cyc = 0;
   int    n_chk = 0;
   int    n_err = 0;
   int    exp_q[$];
   string cur_req = "R1";
   bit    done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // key = cycle*16 + channel, channel = 2*module + (0 for A, 1 for B)
   task automatic expect_ev(input int c, input int ch);
      exp_q.push_back(c * 16 + ch);
      exp_q.sort();
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         while (exp_q.size() > 0 && exp_q[0] / 16 < cyc) begin
            n_chk++; n_err++;
            $display("FAIL %s: missing timeout ch %0d, actual none, expected at cycle %0d",
                     cur_req, exp_q[0] % 16, exp_q[0] / 16);
            void'(exp_q.pop_front());
         end
         for (int ch = 0; ch < 2 * N; ch++) begin
            if ((ch % 2) ? tmo_b[ch/2] : tmo_a[ch/2]) begin
               n_chk++;
               if (exp_q.size() == 0) begin
                  n_err++;
                  $display("FAIL %s: timeout ch %0d at cycle %0d, expected none",
                           cur_req, ch, cyc);
               end else begin
                  int k;
                  k = exp_q.pop_front();
                  if (k != cyc * 16 + ch) begin
                     n_err++;
                     $display("FAIL %s: actual ch %0d cycle %0d, expected ch %0d cycle %0d",
                              cur_req, ch, cyc, k % 16, k / 16);
                  end
               end
            end
         end
      end
   end

   task automatic drain_check();
      n_chk++;
      if (exp_q.size() != 0) begin
         n_err++;
         $display("FAIL %s: %0d timeouts outstanding, expected 0", cur_req, exp_q.size());
      end
      exp_q.delete();
   endtask

   task automatic go(input logic [N-1:0] sa, input logic [N-1:0] sb);
      @(negedge clk);
      s_cyc = cyc; start_a = sa; start_b = sb;
      @(negedge clk);
      start_a = '0; start_b = '0;
   endtask

   task automatic halt();
      @(negedge clk);
      stop_a = '1; stop_b = '1;
      @(negedge clk);
      stop_a = '0; stop_b = '0;
      wait_a = '0; wait_b = '0; per_a = '0; per_b = '0; mod_full = '0;
      ld_a = '0; ld_b = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++; n_chk++;
      done = 1;
      $display("FAIL watchdog: actual run still busy, expected finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      rst_n = 0; mod_full = '0; per_a = '0; per_b = '0; wait_a = '0; wait_b = '0;
      start_a = '0; start_b = '0; stop_a = '0; stop_b = '0; ld_a = '0; ld_b = '0;
      // R1: quiet during and after reset
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         n_chk++;
         if (tmo_a != '0 || tmo_b != '0) begin
            n_err++;
            $display("FAIL R1: tmo_a=%h tmo_b=%h, expected 0 0", tmo_a, tmo_b);
         end
      end
      rst_n = 1;
      idle(5);
      drain_check();

      // R2 / R3: standalone one-shot A0 and periodic B0
      cur_req = "R2_R3";
      ld_a[0 +: W] = 16'd5; ld_b[0 +: W] = 16'd3; per_b[0] = 1'b1;
      go(4'b0001, 4'b0001);
      expect_ev(s_cyc + 6, 0);
      expect_ev(s_cyc + 4, 1); expect_ev(s_cyc + 8, 1); expect_ev(s_cyc + 12, 1);
      idle(13);
      stop_b[0] = 1'b1;
      @(negedge clk); stop_b[0] = 1'b0;
      idle(20);
      drain_check();
      halt();

      // R7: wait bit of module 0 A is ignored
      cur_req = "R7";
      wait_a[0] = 1'b1; ld_a[0 +: W] = 16'd3;
      go(4'b0001, 4'b0000);
      expect_ev(s_cyc + 4, 0);
      idle(10);
      drain_check();
      halt();

      // R4 / R5: split chain A0 -> B0 -> A1 -> B1
      cur_req = "R4_R5";
      ld_a[0 +: W] = 16'd4; ld_b[0 +: W] = 16'd2;
      ld_a[W +: W] = 16'd3; ld_b[W +: W] = 16'd1;
      wait_b[0] = 1'b1; wait_a[1] = 1'b1; wait_b[1] = 1'b1;
      go(4'b0011, 4'b0011);
      expect_ev(s_cyc + 5, 0);
      expect_ev(s_cyc + 8, 1);
      expect_ev(s_cyc + 12, 2);
      expect_ev(s_cyc + 14, 3);
      idle(30);
      drain_check();
      halt();

      // R8: triggers before start are lost
      cur_req = "R8";
      ld_a[0 +: W] = 16'd2; ld_b[0 +: W] = 16'd2; ld_a[W +: W] = 16'd2;
      go(4'b0001, 4'b0000);
      expect_ev(s_cyc + 3, 0);
      idle(6);
      wait_b[0] = 1'b1; wait_a[1] = 1'b1;
      go(4'b0010, 4'b0001);
      idle(40);
      drain_check();
      halt();

      // R9: released periodic B0 keeps running, then stops
      cur_req = "R9";
      ld_a[0 +: W] = 16'd3; ld_b[0 +: W] = 16'd5;
      per_a[0] = 1'b1; per_b[0] = 1'b1; wait_b[0] = 1'b1;
      go(4'b0001, 4'b0001);
      for (int k = 0; k < 7; k++) expect_ev(s_cyc + 4 + 4 * k, 0);
      for (int k = 0; k < 4; k++) expect_ev(s_cyc + 10 + 6 * k, 1);
      idle(29);
      stop_a[0] = 1'b1; stop_b[0] = 1'b1;
      @(negedge clk); stop_a[0] = 1'b0; stop_b[0] = 1'b0;
      idle(20);
      drain_check();
      halt();

      // R6: fused module 0 -> split module 1, fused module 2 with wide load
      cur_req = "R6";
      mod_full = 4'b0101;
      ld_a[0 +: W] = 16'd6; ld_b[0 +: W] = 16'd0; wait_b[0] = 1'b1;
      ld_a[W +: W] = 16'd2; ld_b[W +: W] = 16'd1; wait_a[1] = 1'b1; wait_b[1] = 1'b1;
      ld_a[2*W +: W] = 16'd3; ld_b[2*W +: W] = 16'd1;
      go(4'b0111, 4'b0011);
      expect_ev(s_cyc + 7, 0);
      expect_ev(s_cyc + 10, 2);
      expect_ev(s_cyc + 12, 3);
      expect_ev(s_cyc + 65540, 4);
      idle(65550);
      drain_check();
      halt();

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule